// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, frame clock, data) and turns it into parallel left and right sample words of up to 24 bits, in the system clock domain. The three link wires are oversampled by the system clock. The rising edge of the bit clock is detected after a short synchroniser, and the frame clock and the data are sampled together with that edge.

A static format input selects one of two framing families. With the input high, the block receives I2S words of any length, stored MSB-aligned in a 24-bit word. With the input low, it receives 16-bit right-justified words. A frame-clock high pulse of four bit clocks or fewer switches either family to a DSP-style frame: a short sync pulse followed by a 16-bit left word and then a 16-bit right word. In that case the format input chooses early timing (high) or late timing (low). The block reports the framing it is using, and it also reports when both frame-clock phases last exactly 16 bit clocks (packed 16-bit framing). It gives a one-cycle strobe each time a complete left/right pair is placed on its outputs.

Top module: `aud_serial_rx`

## Requirements
- R1: After reset, both sample outputs are zero, the strobe is low, the mode output is 0 and the packed flag is low.
- R2: With the format input high and the frame clock phases long, the block works in I2S. The frame clock low carries left and high carries right. The MSB is taken on the second rising bit-clock edge after a frame-clock change. A 24-bit word is output unchanged.
- R3: In I2S, a word shorter than 24 bits appears MSB-aligned in the 24-bit output with zeros in the unused low bits.
- R4: In I2S, a word longer than 24 bits is truncated to its 24 most significant bits.
- R5: With the format input low, the block works in right-justified mode. The frame clock high carries left and low carries right. The word is the last 16 bits sampled before the frame-clock change, and it is output in bits 23:8 with bits 7:0 zero.
- R6: A frame-clock high phase of at most 4 bit clocks selects DSP framing, and a phase of 5 or more does not. The mode output encodes 0 = I2S, 1 = right-justified, 2 = DSP early, 3 = DSP late.
- R7: In DSP early mode (format input high), the left MSB is taken one bit clock after the rising edge of the sync pulse. It is followed by 16 left bits and then 16 right bits. Each word is output in bits 23:8.
- R8: In DSP late mode (format input low), every bit is taken one bit clock later than in early mode.
- R9: The packed flag is high when the most recent high phase and the most recent low phase of the frame clock both lasted exactly 16 bit clocks. I2S words are still received correctly with this framing.
- R10: The strobe lasts one system clock and fires once per frame, once the right word has been taken. Left and right outputs change together with it.
- R11: Unequal high and low frame-clock phases are accepted, provided each phase is at least one word long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock |
| fclk_i | input | 1 | Frame / channel clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 1 | Format family select (static) |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| mode_o | output | 2 | Detected framing (0 I2S, 1 right-justified, 2 DSP early, 3 DSP late) |
| packed_o | output | 1 | Both frame-clock phases last exactly 16 bit clocks |

## Verification
I2S is tried with 24-, 20- and 32-bit words, which separates the exact, zero-padded and truncated cases. It is also tried with 16-clock phases, where the LSB falls on the frame-clock edge, and with a 24/40 clock split, where the LSB does the same on only one side. Right-justified frames with 32-clock and 16-clock phases show that the last 16 bits before the edge are kept, whatever the phase length. DSP frames with 1-, 2- and 4-clock sync pulses in early and late timing show the one-clock offset between the two. A 5-clock pulse shows where DSP detection stops. The strobe count over several frames shows that exactly one pair is produced per frame.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [1:0] {
    MODE_I2S       = 2'd0,
    MODE_RJ        = 2'd1,
    MODE_DSP_EARLY = 2'd2,
    MODE_DSP_LATE  = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/aud_rx_sync.sv
// Oversamples the three link wires; gives a one-cycle tick per rising bit-clock
// edge with frame clock and data aligned to it. STAGES must be at least 2.
module aud_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic fclk_i,
  input  logic sdata_i,
  output logic tick_o,
  output logic ws_o,
  output logic sd_o
);
  logic [STAGES:0]   bclk_sr;
  logic [STAGES-1:0] fclk_sr;
  logic [STAGES-1:0] sd_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_sr <= '0;
      fclk_sr <= '0;
      sd_sr   <= '0;
    end else begin
      bclk_sr <= {bclk_sr[STAGES-1:0], bclk_i};
      fclk_sr <= {fclk_sr[STAGES-2:0], fclk_i};
      sd_sr   <= {sd_sr[STAGES-2:0], sdata_i};
    end
  end

  assign tick_o = bclk_sr[STAGES-1] & ~bclk_sr[STAGES];
  assign ws_o   = fclk_sr[STAGES-1];
  assign sd_o   = sd_sr[STAGES-1];

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R10
endmodule

// File: rtl/aud_rx_framer.sv
// Measures frame-clock phases in bit clocks, detects DSP sync pulses and
// packed framing, and times the DSP word capture.
module aud_rx_framer
  import aud_rx_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_MAX = 4,
  parameter int DSP_W     = 16,
  parameter int PACK_LEN  = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     ws,
  input  logic     fmt,
  output logic     trans_o,
  output logic     ws_prev_o,
  output logic     dsp_now_o,
  output logic     dsp_cap_o,
  output rx_mode_e mode_o,
  output logic     packed_o
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] PULSE_LIM = CNT_W'(PULSE_MAX);
  localparam logic [CNT_W-1:0] CAP_EARLY = CNT_W'(2*DSP_W);
  localparam logic [CNT_W-1:0] CAP_LATE  = CNT_W'(2*DSP_W + 1);
  localparam logic [CNT_W-1:0] PACK_CNT  = CNT_W'(PACK_LEN);

  logic             ws_q, dsp_q;
  logic [CNT_W-1:0] ph_q, pos_q, hi_len_q, lo_len_q;
  logic [CNT_W-1:0] ph_len, pos_cur, hi_len_n, lo_len_n;
  logic             trans, rise, fall, dsp_n;
  rx_mode_e         mode_n;

  always_comb begin
    trans    = tick && (ws != ws_q);
    rise     = trans && ws;
    fall     = trans && !ws;
    ph_len   = (ph_q == CNT_MAX) ? ph_q : ph_q + 1'b1;
    pos_cur  = rise ? '0 : ((pos_q == CNT_MAX) ? pos_q : pos_q + 1'b1);
    dsp_n    = fall ? (ph_len <= PULSE_LIM) : dsp_q;
    hi_len_n = (trans && ws_q)  ? ph_len : hi_len_q;
    lo_len_n = (trans && !ws_q) ? ph_len : lo_len_q;
    if (dsp_n) mode_n = fmt ? MODE_DSP_EARLY : MODE_DSP_LATE;
    else       mode_n = fmt ? MODE_I2S : MODE_RJ;
  end

  assign trans_o   = trans;
  assign ws_prev_o = ws_q;
  assign dsp_now_o = dsp_n;
  assign dsp_cap_o = tick && dsp_q && (pos_cur == (fmt ? CAP_EARLY : CAP_LATE));

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q     <= 1'b0;
      dsp_q    <= 1'b0;
      ph_q     <= '0;
      pos_q    <= '0;
      hi_len_q <= '0;
      lo_len_q <= '0;
      mode_o   <= MODE_I2S;
      packed_o <= 1'b0;
    end else if (tick) begin
      ws_q     <= ws;
      dsp_q    <= dsp_n;
      ph_q     <= trans ? '0 : ph_len;
      pos_q    <= pos_cur;
      hi_len_q <= hi_len_n;
      lo_len_q <= lo_len_n;
      mode_o   <= mode_n;
      packed_o <= (hi_len_n == PACK_CNT) && (lo_len_n == PACK_CNT);
    end
  end

  AST_MODE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(mode_o)); // R6
  AST_CAP_NEEDS_DSP: assert property (@(posedge clk) disable iff (rst)
    dsp_cap_o |-> mode_o[1]); // R7
endmodule

// File: rtl/aud_rx_capture.sv
// Assembles words from the serial stream and presents left/right pairs.
module aud_rx_capture #(
  parameter int SAMPLE_W = 24,
  parameter int RJ_W     = 16,
  parameter int DSP_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                sd,
  input  logic                fmt,
  input  logic                trans,
  input  logic                ws_prev,
  input  logic                dsp_now,
  input  logic                dsp_cap,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int NW    = $clog2(SAMPLE_W + 1);
  localparam int SH_W  = 2 * DSP_W;
  localparam int PAD_R = SAMPLE_W - RJ_W;
  localparam int PAD_D = SAMPLE_W - DSP_W;
  localparam logic [NW-1:0] IDX_TOP = NW'(SAMPLE_W - 1);
  localparam logic [NW-1:0] N_FULL  = NW'(SAMPLE_W);

  logic [SH_W-1:0]     sh_q, sh_cur;
  logic [SAMPLE_W-1:0] acc_q, acc_full, std_word, pend_q;
  logic [NW-1:0]       n_q;
  logic                room, is_left;

  always_comb begin
    room     = n_q < N_FULL;
    acc_full = acc_q;
    if (room) acc_full[IDX_TOP - n_q] = sd;
    sh_cur   = {sh_q[SH_W-2:0], sd};
    std_word = fmt ? acc_full : {sh_q[RJ_W-1:0], {PAD_R{1'b0}}};
    is_left  = fmt ? !ws_prev : ws_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      acc_q   <= '0;
      n_q     <= '0;
      pend_q  <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick) begin
        sh_q <= sh_cur;
        if (trans) begin
          acc_q <= '0;
          n_q   <= '0;
        end else if (room) begin
          acc_q <= acc_full;
          n_q   <= n_q + 1'b1;
        end
      end
      if (trans && !dsp_now) begin
        if (is_left) begin
          pend_q <= std_word;
        end else begin
          left_o  <= pend_q;
          right_o <= std_word;
          valid_o <= 1'b1;
        end
      end
      if (dsp_cap) begin
        left_o  <= {sh_cur[SH_W-1:DSP_W], {PAD_D{1'b0}}};
        right_o <= {sh_cur[DSP_W-1:0], {PAD_D{1'b0}}};
        valid_o <= 1'b1;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R10
  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(tick)); // R10
  AST_SHORT_WORD_PAD: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !fmt) |-> (left_o[PAD_R-1:0] == '0 && right_o[PAD_R-1:0] == '0)); // R5
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SYNC_STG  = 2,
  parameter int CNT_W     = 8,
  parameter int PULSE_MAX = 4,
  parameter int WORD16    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_i,
  input  logic                fclk_i,
  input  logic                sdata_i,
  input  logic                fmt_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic [1:0]          mode_o,
  output logic                packed_o
);
  logic     tick, ws, sd;
  logic     trans, ws_prev, dsp_now, dsp_cap;
  rx_mode_e mode_w;

  aud_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .fclk_i(fclk_i), .sdata_i(sdata_i),
    .tick_o(tick), .ws_o(ws), .sd_o(sd)
  );

  aud_rx_framer #(
    .CNT_W(CNT_W), .PULSE_MAX(PULSE_MAX), .DSP_W(WORD16), .PACK_LEN(WORD16)
  ) u_framer (
    .clk(clk), .rst(rst), .tick(tick), .ws(ws), .fmt(fmt_i),
    .trans_o(trans), .ws_prev_o(ws_prev), .dsp_now_o(dsp_now),
    .dsp_cap_o(dsp_cap), .mode_o(mode_w), .packed_o(packed_o)
  );

  aud_rx_capture #(
    .SAMPLE_W(SAMPLE_W), .RJ_W(WORD16), .DSP_W(WORD16)
  ) u_capture (
    .clk(clk), .rst(rst), .tick(tick), .sd(sd), .fmt(fmt_i), .trans(trans),
    .ws_prev(ws_prev), .dsp_now(dsp_now), .dsp_cap(dsp_cap),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  assign mode_o = mode_w;
endmodule

// File: tb/aud_serial_rx_tb.sv
module aud_serial_rx_tb;
  import aud_rx_pkg::*;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bclk = 1'b0, fclk = 1'b0, sdata = 1'b0, fmt = 1'b1;
  logic [23:0] left, right;
  logic        valid, packed_f;
  logic [1:0]  mode;

  int          checks = 0, errors = 0, nval = 0;
  logic [23:0] cap_l = '0, cap_r = '0;
  logic        carry = 1'b0;

  always #4 clk = ~clk;

  aud_serial_rx u_dut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .fclk_i(fclk), .sdata_i(sdata),
    .fmt_i(fmt), .left_o(left), .right_o(right), .valid_o(valid),
    .mode_o(mode), .packed_o(packed_f)
  );

  always @(negedge clk) begin
    if (!rst && valid) begin
      cap_l = left;
      cap_r = right;
      nval++;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_bit(logic w, logic d);
    fclk = w; sdata = d; bclk = 1'b0;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  function automatic logic [23:0] align(logic [31:0] x, int w);
    if (w <= 24) return 24'(x << (24 - w));
    return 24'(x >> (w - 24));
  endfunction

  task automatic i2s_frame(logic [31:0] l, logic [31:0] r, int w, int pl, int ph);
    for (int k = 0; k < pl; k++) put_bit(1'b0, (k == 0) ? carry : ((k <= w) ? l[w-k] : 1'b0));
    carry = (w == pl) ? l[0] : 1'b0;
    for (int k = 0; k < ph; k++) put_bit(1'b1, (k == 0) ? carry : ((k <= w) ? r[w-k] : 1'b0));
    carry = (w == ph) ? r[0] : 1'b0;
  endtask

  task automatic i2s_case(string tag, logic [31:0] l, logic [31:0] r, int w, int pl, int ph);
    fmt = 1'b1;
    for (int f = 0; f < 4; f++) i2s_frame(l, r, w, pl, ph);
    settle();
    check({tag, " left"}, 32'(cap_l), 32'(align(l, w)));
    check({tag, " right"}, 32'(cap_r), 32'(align(r, w)));
  endtask

  task automatic rj_frame(logic [15:0] l, logic [15:0] r, int p);
    for (int k = 0; k < p; k++) put_bit(1'b1, (k >= p - 16) ? l[p-1-k] : 1'b0);
    for (int k = 0; k < p; k++) put_bit(1'b0, (k >= p - 16) ? r[p-1-k] : 1'b0);
  endtask

  task automatic rj_case(string tag, logic [15:0] l, logic [15:0] r, int p);
    fmt = 1'b0;
    for (int f = 0; f < 4; f++) rj_frame(l, r, p);
    settle();
    check({tag, " left"}, 32'(cap_l), 32'({l, 8'h00}));
    check({tag, " right"}, 32'(cap_r), 32'({r, 8'h00}));
    check({tag, " mode"}, 32'(mode), 32'(MODE_RJ));
  endtask

  task automatic dsp_frame(logic [15:0] l, logic [15:0] r, int pw, int off);
    for (int t = 0; t < 64; t++) begin
      int idx = t - off;
      logic d = 1'b0;
      if (idx >= 0 && idx < 16) d = l[15-idx];
      else if (idx >= 16 && idx < 32) d = r[31-idx];
      put_bit(t < pw, d);
    end
  endtask

  task automatic dsp_case(string tag, logic early, logic [15:0] l, logic [15:0] r, int pw);
    fmt = early;
    for (int f = 0; f < 3; f++) dsp_frame(l, r, pw, early ? 1 : 2);
    settle();
    check({tag, " left"}, 32'(cap_l), 32'({l, 8'h00}));
    check({tag, " right"}, 32'(cap_r), 32'({r, 8'h00}));
    check({tag, " mode"}, 32'(mode), early ? 32'(MODE_DSP_EARLY) : 32'(MODE_DSP_LATE));
  endtask

  task automatic test_reset();
    check("R1 left", 32'(left), 32'h0);
    check("R1 right", 32'(right), 32'h0);
    check("R1 valid", 32'(valid), 32'h0);
    check("R1 mode", 32'(mode), 32'h0);
    check("R1 packed", 32'(packed_f), 32'h0);
  endtask

  task automatic test_strobe_count();
    int n0;
    fmt = 1'b1;
    i2s_frame(32'h13579B, 32'hECA864, 24, 24, 40);
    n0 = nval;
    for (int f = 0; f < 3; f++) i2s_frame(32'h13579B, 32'hECA864, 24, 24, 40);
    settle();
    check("R11 left", 32'(cap_l), 32'h13579B);
    check("R11 right", 32'(cap_r), 32'hECA864);
    check("R10 strobes per frame", 32'(nval - n0), 32'd3);
  endtask

  task automatic test_not_dsp();
    fmt = 1'b1;
    for (int f = 0; f < 3; f++) dsp_frame(16'hFFFF, 16'h0001, 5, 1);
    settle();
    check("R6 five-clock pulse is not DSP", 32'(mode), 32'(MODE_I2S));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    test_reset();
    i2s_case("R2 i2s 24-bit", 32'hA5C3F1, 32'h3E1B7D, 24, 32, 32);
    check("R2 mode", 32'(mode), 32'(MODE_I2S));
    check("R9 not packed at 32", 32'(packed_f), 32'h0);
    i2s_case("R3 i2s 20-bit pad", 32'h9ABCD, 32'h1234F, 20, 32, 32);
    i2s_case("R4 i2s 32-bit truncate", 32'hDEADBEEF, 32'h8BADF00D, 32, 32, 32);
    i2s_case("R9 i2s packed 16", 32'hC3A5, 32'h5A3C, 16, 16, 16);
    check("R9 packed flag", 32'(packed_f), 32'h1);
    test_strobe_count();
    rj_case("R5 rj 32-clock phases", 16'hB7E1, 16'h4C29, 32);
    check("R9 rj not packed", 32'(packed_f), 32'h0);
    rj_case("R9 rj packed 16", 16'h8001, 16'h7FFE, 16);
    check("R9 rj packed flag", 32'(packed_f), 32'h1);
    dsp_case("R7 dsp early pw1", 1'b1, 16'hA1B2, 16'hC3D4, 1);
    dsp_case("R6 dsp early pw4", 1'b1, 16'h1357, 16'h9BDF, 4);
    dsp_case("R8 dsp late pw2", 1'b0, 16'h6E5D, 16'h4C3B, 2);
    test_not_dsp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule